// File: doc/BRIEF.md
# Reloadable 16-bit down-counter timer

This block is one timer channel. A 16-bit counter counts down by one on each single-cycle count tick while the channel is running. A tick that arrives while the counter holds zero is an underflow. On an underflow the counter takes the value held in a separate reload register instead of wrapping, and an underflow flag is set. A software preset command copies the reload value into the counter at any time.

The channel has two modes. In repeat mode it keeps running after an underflow. In one-shot mode it stops itself on the cycle of the first underflow. The interrupt request output is high while the underflow flag is set and the interrupt enable bit is 1.

Software reaches the channel through a small register bus. Writes take one clock cycle. Reads are combinational from the address. Clock selection and prescaling are outside the block: the count clock arrives only as the tick input.

Top module: `tmr16_chan`

## Requirements
- R1: After reset, the reload and count registers read 0xFFFF, the control, flag and enable registers read 0, and `irq` is 0.
- R2: The reload register (address 0) can be written and read back while the run bit is 0. A write to it while the run bit is 1 is ignored.
- R3: The count register (address 1) returns the live count, and writes to address 1 have no effect.
- R4: Writing the control register (address 2) with bit 1 set loads the reload value into the counter on that clock edge, whether the channel is running or stopped. Bit 1 always reads as 0.
- R5: The control register holds the run bit at bit 0 and the mode bit at bit 4 (0 = repeat, 1 = one-shot). While run is 1, each tick lowers a nonzero count by exactly one. While run is 0, ticks leave the count unchanged.
- R6: A tick while run is 1 and the count is 0x0000 is an underflow. On that edge the counter takes the reload value and the flag is set.
- R7: In repeat mode the run bit stays 1 across an underflow, so the count repeats with a period of reload + 1 ticks.
- R8: In one-shot mode an underflow clears the run bit, and later ticks leave the reloaded count unchanged.
- R9: The underflow flag is bit 0 of address 3. Writing 1 to bit 0 clears it, writing 0 has no effect, and bits 15 to 1 read as 0.
- R10: If an underflow and a write of 1 to the flag happen in the same cycle, the flag ends up set.
- R11: `irq` equals the flag AND the enable bit.
- R12: The enable bit is bit 0 of address 4 and can be read and written. Bits 15 to 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle count pulse |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Underflow interrupt request |

## Verification
The hardest case to reach from the ports is an underflow that lands in the same cycle as a software write that clears the flag. The bench gets there with a reload value of zero. With that value every running tick is an underflow, so the flag write and the tick can be driven together in one step. The bench also sweeps small reload values through several full periods in repeat mode, and checks every count against the value it expects from the tick number.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd4;

  localparam int unsigned CTL_RUN    = 0;
  localparam int unsigned CTL_PRESET = 1;
  localparam int unsigned CTL_MODE   = 4;

  // Next count for a running tick: underflow reloads, otherwise decrement.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              uflow,
  output logic [W-1:0]      reload_o,
  output logic              run_o,
  output logic              mode_o,
  output logic              preset_o,
  output logic              en_o
);
  logic [W-1:0] reload_q;
  logic         run_q, mode_q, en_q;
  logic         wr_reload, wr_ctrl, wr_en;

  assign wr_reload = wen && (addr == A_RELOAD) && !run_q;
  assign wr_ctrl   = wen && (addr == A_CTRL);
  assign wr_en     = wen && (addr == A_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      run_q    <= 1'b0;
      mode_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl)   mode_q   <= wdata[CTL_MODE];
      if (uflow && mode_q) run_q <= 1'b0;
      else if (wr_ctrl)    run_q <= wdata[CTL_RUN];
      if (wr_en)     en_q     <= wdata[0];
    end
  end

  assign reload_o = reload_q;
  assign run_o    = run_q;
  assign mode_o   = mode_q;
  assign preset_o = wr_ctrl && wdata[CTL_PRESET];
  assign en_o     = en_q;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         preset,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step    = tick && run && !preset;
  assign uflow_o = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (preset) cnt_q <= reload;
    else if (step)   cnt_q <= next_count(cnt_q, reload);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en;
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
  import tmr16_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq
);
  logic [W-1:0] reload, cnt;
  logic         run, mode, preset, en, uflow, flag, flag_clr;

  tmr16_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .uflow(uflow), .reload_o(reload), .run_o(run), .mode_o(mode),
    .preset_o(preset), .en_o(en)
  );

  tmr16_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .preset(preset),
    .reload(reload), .cnt_o(cnt), .uflow_o(uflow)
  );

  assign flag_clr = bus_wen && (bus_addr == A_FLAG) && bus_wdata[0];

  tmr16_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(uflow), .clr(flag_clr), .en(en),
    .flag_o(flag), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RELOAD: bus_rdata = reload;
      A_COUNT:  bus_rdata = cnt;
      A_CTRL: begin
        bus_rdata[CTL_RUN]  = run;
        bus_rdata[CTL_MODE] = mode;
      end
      A_FLAG:   bus_rdata[0] = flag;
      A_ENABLE: bus_rdata[0] = en;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         mode,
  input logic         preset,
  input logic         uflow,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic         flag,
  input logic         en,
  input logic         irq
);
  AST_RELOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(reload)); // R2
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (cnt == $past(reload))); // R4
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !preset && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !preset) |=> $stable(cnt)); // R5
  AST_UFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> flag); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && mode) |=> !run); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq); // R11
endmodule

bind tmr16_chan tmr16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
  .preset(preset), .uflow(uflow), .cnt(cnt), .reload(reload),
  .flag(flag), .en(en), .irq(irq)
);

// File: tb/tb_tmr16_chan.sv
module tb_tmr16_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  tmr16_chan dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d, input logic t);
    @(negedge clk);
    bus_wen = w; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk); #1;
    bus_wen = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 reload", 3'd0, 16'hFFFF);
    chk_reg("R1 count", 3'd1, 16'hFFFF);
    chk_reg("R1 ctrl", 3'd2, 16'h0000);
    chk_reg("R1 flag", 3'd3, 16'h0000);
    chk_reg("R1 enable", 3'd4, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);

    // R5 ticks ignored while stopped
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 3'd0, 16'd0, 1'b1);
      chk_reg("R5 stopped hold", 3'd1, 16'hFFFF);
    end

    // R12 enable read/write, upper bits zero
    step(1'b1, 3'd4, 16'hFFFF, 1'b0);
    chk_reg("R12 enable set", 3'd4, 16'h0001);
    step(1'b1, 3'd4, 16'hFFFE, 1'b0);
    chk_reg("R12 enable clr", 3'd4, 16'h0000);

    // R2 / R3 while stopped
    step(1'b1, 3'd0, 16'h00A5, 1'b0);
    chk_reg("R2 reload write", 3'd0, 16'h00A5);
    step(1'b1, 3'd1, 16'h0005, 1'b0);
    chk_reg("R3 count write ignored", 3'd1, 16'hFFFF);

    // R4 preset while stopped; preset bit reads 0
    step(1'b1, 3'd2, 16'h0002, 1'b0);
    chk_reg("R4 preset stopped", 3'd1, 16'h00A5);
    chk_reg("R4 preset reads 0", 3'd2, 16'h0000);

    // R5/R6/R7 sweep of reload values in repeat mode
    for (int r = 1; r <= 6; r++) begin
      step(1'b1, 3'd2, 16'h0000, 1'b0);
      step(1'b1, 3'd0, 16'(r), 1'b0);
      step(1'b1, 3'd2, 16'h0002, 1'b0);
      step(1'b1, 3'd3, 16'h0001, 1'b0);
      step(1'b1, 3'd2, 16'h0001, 1'b0);
      for (int k = 1; k <= 2 * (r + 1) + 1; k++) begin
        step(1'b0, 3'd0, 16'd0, 1'b1);
        chk_reg("R5 R6 R7 repeat count", 3'd1, 16'(r - (k % (r + 1))));
        if (k == r) chk_reg("R6 flag clear before underflow", 3'd3, 16'h0000);
        if (k == r + 1) chk_reg("R6 flag on underflow", 3'd3, 16'h0001);
      end
      chk_reg("R7 still running", 3'd2, 16'h0001);
      // R2 reload write ignored while running
      step(1'b1, 3'd0, 16'h1234, 1'b0);
      chk_reg("R2 reload locked", 3'd0, 16'(r));
    end

    // R4 preset while running
    step(1'b1, 3'd2, 16'h0003, 1'b0);
    chk_reg("R4 preset running", 3'd1, 16'h0006);

    // R9 flag write 0 no effect, write 1 clears
    chk_reg("R9 flag set", 3'd3, 16'h0001);
    step(1'b1, 3'd3, 16'hFFFE, 1'b0);
    chk_reg("R9 write 0 ignored", 3'd3, 16'h0001);
    // R11 irq with enable
    check("R11 irq disabled", {15'd0, irq}, 16'd0);
    step(1'b1, 3'd4, 16'h0001, 1'b0);
    check("R11 irq enabled", {15'd0, irq}, 16'd1);
    step(1'b1, 3'd3, 16'h0001, 1'b0);
    chk_reg("R9 write 1 clears", 3'd3, 16'h0000);
    check("R11 irq after clear", {15'd0, irq}, 16'd0);

    // R8 one-shot with reload 3
    step(1'b1, 3'd2, 16'h0000, 1'b0);
    step(1'b1, 3'd0, 16'h0003, 1'b0);
    step(1'b1, 3'd2, 16'h0002, 1'b0);
    step(1'b1, 3'd2, 16'h0011, 1'b0);
    chk_reg("R8 one-shot ctrl", 3'd2, 16'h0011);
    for (int k = 1; k <= 4; k++) begin
      step(1'b0, 3'd0, 16'd0, 1'b1);
      chk_reg("R8 one-shot count", 3'd1, 16'(k == 4 ? 3 : 3 - k));
    end
    chk_reg("R8 run cleared", 3'd2, 16'h0010);
    chk_reg("R8 flag", 3'd3, 16'h0001);
    check("R11 irq one-shot", {15'd0, irq}, 16'd1);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 3'd0, 16'd0, 1'b1);
      chk_reg("R8 stopped after one-shot", 3'd1, 16'h0003);
    end

    // R10 set wins: reload 0 makes every running tick an underflow
    step(1'b1, 3'd2, 16'h0000, 1'b0);
    step(1'b1, 3'd0, 16'h0000, 1'b0);
    step(1'b1, 3'd2, 16'h0002, 1'b0);
    step(1'b1, 3'd3, 16'h0001, 1'b0);
    step(1'b1, 3'd2, 16'h0001, 1'b0);
    chk_reg("R10 flag cleared first", 3'd3, 16'h0000);
    step(1'b1, 3'd3, 16'h0001, 1'b1);
    chk_reg("R10 set wins", 3'd3, 16'h0001);
    chk_reg("R6 reload zero", 3'd1, 16'h0000);

    rd(3'd0, v);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule